// File: doc/BRIEF.md
# Memoizing Multiply-Add Lookup Table

This block stands in for an arithmetic multiply-add unit inside an inference accelerator. Each request carries a 16-bit hash key derived from the operands. The low index bits of the key select one set of a small set-associative on-chip table. The remaining key bits form a tag. If a valid way in that set holds a matching tag, the stored result is returned one cycle after the request, and no arithmetic takes place.

On a miss the block raises a compute enable toward an external arithmetic unit. It holds the enable and the key until that unit signals completion. It then returns the supplied result, flags it as a miss, and writes it into the set.

Collisions are deliberately left unresolved. Any two requests with equal set index and equal stored tag are treated as the same operands. The stored tag may be shortened by dropping its lowest bits, which raises the hit rate at the cost of accuracy. A pair of counters reports how many hit and miss responses have been produced.

Top module: `memo_madd_table`

## Requirements
- R1: After reset every way is invalid, `req_ready` is 1, `calc_en` and `rsp_valid` are 0, and both counters read 0.
- R2: Key bits [IDX_W-1:0] select the set and key bits [KEY_W-1:IDX_W] form the full tag. Equal tags in different sets do not match.
- R3: A request accepted on a hit produces `rsp_valid`=1, `rsp_hit`=1 and the stored result in the cycle after acceptance, with `calc_en` staying 0.
- R4: A request accepted on a miss raises `calc_en` in the next cycle, with `calc_key` equal to the request key. `calc_en`, `calc_key` and `req_ready`=0 hold until `calc_done` is sampled high.
- R5: In the cycle after `calc_done` is sampled high, `rsp_valid`=1, `rsp_hit`=0, `rsp_data` equals `calc_result` and `calc_en` is 0. The result is stored for later hits on that key.
- R6: Two keys in the same set with different stored tags are distinct entries. Each key misses once and then both hit.
- R7: With TAG_DROP=d, the lowest d tag bits (key bits IDX_W to IDX_W+d-1) are ignored. Keys differing only there return the first key's stored result as a hit.
- R8: A fill uses the lowest-numbered invalid way of the set, so the first WAYS distinct tags in a set all stay resident.
- R9: When the set is full, fills replace ways in round-robin order starting at way 0. The pointer advances only on such replacements.
- R10: `hit_count` and `miss_count` each increase by exactly one for every hit or miss response, respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_key | input | KEY_W | Hash key of the operands |
| calc_en | output | 1 | Enable to the external arithmetic unit |
| calc_key | output | KEY_W | Key of the missing request |
| calc_done | input | 1 | External result is valid |
| calc_result | input | RES_W | External multiply-add result |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_hit | output | 1 | 1 if served from the table |
| rsp_data | output | RES_W | Result value |
| hit_count | output | CNT_W | Number of hit responses |
| miss_count | output | CNT_W | Number of miss responses |

## Verification
A corrupted valid bit or tag shows up at the ports on the next request to that set. A stale entry turns an expected miss into a hit with the wrong data. A lost entry raises `calc_en` where a hit was due. A wrong round-robin pointer becomes visible only after a set has been filled past WAYS entries. The eviction sequences therefore fill one set beyond capacity and probe each earlier key in a chosen order. The tag-shortened instance is driven with keys that differ only in dropped bits, and its results are compared against the full-tag instance.

// File: rtl/memo_pkg.sv
package memo_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } memo_state_e;
endpackage

// File: rtl/memo_key_split.sv
module memo_key_split #(
   parameter int KEY_W    = 16,
   parameter int IDX_W    = 6,
   parameter int TAG_DROP = 0,
   localparam int FULL_W  = KEY_W - IDX_W,
   localparam int TAG_W   = FULL_W - TAG_DROP
) (
   input  logic [KEY_W-1:0] key,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   logic [FULL_W-1:0] full_tag;

   assign idx      = key[IDX_W-1:0];
   assign full_tag = key[KEY_W-1:IDX_W];

   generate
      if (TAG_DROP == 0) begin : g_full_tag
         assign tag = full_tag;
      end else begin : g_short_tag
         assign tag = full_tag[FULL_W-1:TAG_DROP];
      end
   endgenerate
endmodule

// File: rtl/memo_set_store.sv
module memo_set_store #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 10,
   parameter int RES_W = 32,
   parameter int WAYS  = 4,
   localparam int SETS = 1 << IDX_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [WAYS-1:0]                  rd_valid,
   output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
   output logic [WAYS-1:0][RES_W-1:0]       rd_data,
   input  logic                             wr_en,
   input  logic [WAYS-1:0]                  wr_way,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic [RES_W-1:0]                 wr_data
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic [SETS-1:0]  valid_q;
         logic [TAG_W-1:0] tag_q  [SETS];
         logic [RES_W-1:0] data_q [SETS];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= '0;
            end else if (wr_en && wr_way[w]) begin
               valid_q[wr_idx] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_en && wr_way[w]) begin
               tag_q[wr_idx]  <= wr_tag;
               data_q[wr_idx] <= wr_data;
            end
         end

         assign rd_valid[w] = valid_q[rd_idx];
         assign rd_tag[w]   = tag_q[rd_idx];
         assign rd_data[w]  = data_q[rd_idx];
      end
   endgenerate
endmodule

// File: rtl/memo_way_match.sv
module memo_way_match #(
   parameter int TAG_W = 10,
   parameter int RES_W = 32,
   parameter int WAYS  = 4
) (
   input  logic [WAYS-1:0]            rd_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
   input  logic [WAYS-1:0][RES_W-1:0] rd_data,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [RES_W-1:0]           hit_data
);
   always_comb begin
      hit_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_vec[w] = rd_valid[w] && (rd_tag[w] == tag);
         if (hit_vec[w]) begin
            hit_data = hit_data | rd_data[w];
         end
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/memo_victim.sv
module memo_victim #(
   parameter int IDX_W  = 6,
   parameter int WAYS   = 4,
   localparam int SETS  = 1 << IDX_W,
   localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  rd_valid,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             fill_replaces,
   output logic [WAYS-1:0]  victim
);
   generate
      if (WAYS == 1) begin : g_direct
         assign victim = 1'b1;
      end else begin : g_rr
         logic [PTR_W-1:0] rr_q [SETS];
         logic             found;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) begin
                  rr_q[s] <= '0;
               end
            end else if (fill_en && fill_replaces) begin
               rr_q[fill_idx] <= rr_q[fill_idx] + 1'b1;
            end
         end

         always_comb begin
            victim = '0;
            found  = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
               if (!rd_valid[w] && !found) begin
                  victim[w] = 1'b1;
                  found     = 1'b1;
               end
            end
            if (!found) begin
               victim[rr_q[idx]] = 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/memo_madd_table.sv
module memo_madd_table #(
   parameter int KEY_W    = 16,
   parameter int IDX_W    = 6,
   parameter int WAYS     = 4,
   parameter int RES_W    = 32,
   parameter int TAG_DROP = 0,
   parameter int CNT_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [KEY_W-1:0] req_key,
   output logic             calc_en,
   output logic [KEY_W-1:0] calc_key,
   input  logic             calc_done,
   input  logic [RES_W-1:0] calc_result,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [RES_W-1:0] rsp_data,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   import memo_pkg::*;

   localparam int FULL_W = KEY_W - IDX_W;
   localparam int TAG_W  = FULL_W - TAG_DROP;

   generate
      if (IDX_W < 1 || IDX_W > 9) begin : g_bad_idx
         $error("IDX_W must lie between 1 and 9");
      end
      if (!(WAYS == 1 || WAYS == 2 || WAYS == 4)) begin : g_bad_ways
         $error("WAYS must be 1, 2 or 4");
      end
      if (TAG_DROP < 0 || TAG_DROP >= FULL_W) begin : g_bad_drop
         $error("TAG_DROP must leave at least one tag bit");
      end
      if (RES_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("RES_W and CNT_W must be positive");
      end
   endgenerate

   memo_state_e             st_q;
   logic [IDX_W-1:0]        look_idx;
   logic [TAG_W-1:0]        look_tag;
   logic [WAYS-1:0]         rd_valid;
   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic [WAYS-1:0][RES_W-1:0] rd_data;
   logic [WAYS-1:0]         hit_vec;
   logic                    look_hit;
   logic [RES_W-1:0]        look_data;
   logic [WAYS-1:0]         victim;
   logic                    accept;
   logic                    fill;

   logic [KEY_W-1:0]        key_q;
   logic [IDX_W-1:0]        idx_q;
   logic [TAG_W-1:0]        tag_q;
   logic [WAYS-1:0]         vic_q;
   logic                    repl_q;

   memo_key_split #(
      .KEY_W    (KEY_W),
      .IDX_W    (IDX_W),
      .TAG_DROP (TAG_DROP)
   ) u_split (
      .key (req_key),
      .idx (look_idx),
      .tag (look_tag)
   );

   memo_set_store #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .RES_W (RES_W),
      .WAYS  (WAYS)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (look_idx),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .wr_en    (fill),
      .wr_way   (vic_q),
      .wr_idx   (idx_q),
      .wr_tag   (tag_q),
      .wr_data  (calc_result)
   );

   memo_way_match #(
      .TAG_W (TAG_W),
      .RES_W (RES_W),
      .WAYS  (WAYS)
   ) u_match (
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .tag      (look_tag),
      .hit_vec  (hit_vec),
      .hit      (look_hit),
      .hit_data (look_data)
   );

   memo_victim #(
      .IDX_W (IDX_W),
      .WAYS  (WAYS)
   ) u_victim (
      .clk           (clk),
      .rst_n         (rst_n),
      .idx           (look_idx),
      .rd_valid      (rd_valid),
      .fill_en       (fill),
      .fill_idx      (idx_q),
      .fill_replaces (repl_q),
      .victim        (victim)
   );

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign fill      = (st_q == ST_WAIT) && calc_done;
   assign calc_en   = (st_q == ST_WAIT);
   assign calc_key  = key_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         key_q      <= '0;
         idx_q      <= '0;
         tag_q      <= '0;
         vic_q      <= '0;
         repl_q     <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_data   <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (look_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_hit   <= 1'b1;
                     rsp_data  <= look_data;
                     hit_count <= hit_count + 1'b1;
                  end else begin
                     st_q   <= ST_WAIT;
                     key_q  <= req_key;
                     idx_q  <= look_idx;
                     tag_q  <= look_tag;
                     vic_q  <= victim;
                     repl_q <= &rd_valid;
                  end
               end
            end
            ST_WAIT: begin
               if (calc_done) begin
                  st_q       <= ST_IDLE;
                  rsp_valid  <= 1'b1;
                  rsp_hit    <= 1'b0;
                  rsp_data   <= calc_result;
                  miss_count <= miss_count + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/memo_madd_table_chk.sv
module memo_madd_table_chk #(
   parameter int KEY_W = 16,
   parameter int WAYS  = 4,
   parameter int RES_W = 32,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [KEY_W-1:0] req_key,
   input logic             calc_en,
   input logic [KEY_W-1:0] calc_key,
   input logic             calc_done,
   input logic [RES_W-1:0] calc_result,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic [RES_W-1:0] rsp_data,
   input logic [CNT_W-1:0] hit_count,
   input logic [CNT_W-1:0] miss_count,
   input logic [WAYS-1:0]  hit_vec,
   input logic             look_hit
);
   // R3
   hit_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && look_hit) |=> (rsp_valid && rsp_hit && !calc_en));

   // R4
   miss_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !look_hit) |=>
         (calc_en && !req_ready && calc_key == $past(req_key)));

   // R4
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_en && !calc_done) |=> (calc_en && $stable(calc_key)));

   // R5
   miss_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_en && calc_done) |=>
         (rsp_valid && !rsp_hit && !calc_en && rsp_data == $past(calc_result)));

   // R4
   no_rsp_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      calc_en |-> !rsp_valid);

   // R8
   single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R10
   hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + 1'b1));

   // R10
   miss_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + 1'b1));
endmodule

bind memo_madd_table memo_madd_table_chk #(
   .KEY_W (KEY_W),
   .WAYS  (WAYS),
   .RES_W (RES_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_key     (req_key),
   .calc_en     (calc_en),
   .calc_key    (calc_key),
   .calc_done   (calc_done),
   .calc_result (calc_result),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_data    (rsp_data),
   .hit_count   (hit_count),
   .miss_count  (miss_count),
   .hit_vec     (hit_vec),
   .look_hit    (look_hit)
);

// File: tb/test_memo_madd_table.sv
`timescale 1ns/1ps
module test_memo_madd_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid   [2];
   logic [15:0] req_key     [2];
   logic        calc_done   [2];
   logic [31:0] calc_result [2];
   logic        req_ready   [2];
   logic        calc_en     [2];
   logic [15:0] calc_key    [2];
   logic        rsp_valid   [2];
   logic        rsp_hit     [2];
   logic [31:0] rsp_data    [2];
   logic [31:0] hit_count   [2];
   logic [31:0] miss_count  [2];

   int checks = 0;
   int errors = 0;
   int exp_hits   [2] = '{0, 0};
   int exp_misses [2] = '{0, 0};

   always #2 clk = ~clk;

   memo_madd_table #(.IDX_W(6), .WAYS(4), .TAG_DROP(0)) i_memo_madd_table (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid[0]), .req_ready (req_ready[0]), .req_key (req_key[0]),
      .calc_en (calc_en[0]), .calc_key (calc_key[0]),
      .calc_done (calc_done[0]), .calc_result (calc_result[0]),
      .rsp_valid (rsp_valid[0]), .rsp_hit (rsp_hit[0]), .rsp_data (rsp_data[0]),
      .hit_count (hit_count[0]), .miss_count (miss_count[0])
   );

   memo_madd_table #(.IDX_W(6), .WAYS(4), .TAG_DROP(2)) i_memo_madd_table_short (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid[1]), .req_ready (req_ready[1]), .req_key (req_key[1]),
      .calc_en (calc_en[1]), .calc_key (calc_key[1]),
      .calc_done (calc_done[1]), .calc_result (calc_result[1]),
      .rsp_valid (rsp_valid[1]), .rsp_hit (rsp_hit[1]), .rsp_data (rsp_data[1]),
      .hit_count (hit_count[1]), .miss_count (miss_count[1])
   );

   function automatic logic [31:0] res_of(input logic [15:0] k);
      return {k ^ 16'h5A5A, ~k};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One lookup on instance s. On a miss, data is what the arithmetic unit returns.
   task automatic do_req(input int s, input logic [15:0] key, input bit exp_hit,
                         input logic [31:0] data, input string req);
      @(negedge clk);
      req_valid[s] = 1'b1;
      req_key[s]   = key;
      @(negedge clk);
      req_valid[s] = 1'b0;
      if (exp_hit) begin
         exp_hits[s]++;
         chk(req, "hit rsp_valid", 32'(rsp_valid[s]), 32'd1);
         chk(req, "hit rsp_hit", 32'(rsp_hit[s]), 32'd1);
         chk(req, "hit rsp_data", rsp_data[s], data);
         chk(req, "hit calc_en", 32'(calc_en[s]), 32'd0);
      end else begin
         exp_misses[s]++;
         chk(req, "miss calc_en", 32'(calc_en[s]), 32'd1);
         chk(req, "miss calc_key", 32'(calc_key[s]), 32'(key));
         chk(req, "miss req_ready", 32'(req_ready[s]), 32'd0);
         chk(req, "miss rsp_valid early", 32'(rsp_valid[s]), 32'd0);
         repeat (2) @(negedge clk);
         chk("R4", "calc_en held", 32'(calc_en[s]), 32'd1);
         chk("R4", "calc_key held", 32'(calc_key[s]), 32'(key));
         calc_done[s]   = 1'b1;
         calc_result[s] = data;
         @(negedge clk);
         calc_done[s]   = 1'b0;
         calc_result[s] = 32'hDEAD_BEEF;
         chk("R5", "fill rsp_valid", 32'(rsp_valid[s]), 32'd1);
         chk("R5", "fill rsp_hit", 32'(rsp_hit[s]), 32'd0);
         chk("R5", "fill rsp_data", rsp_data[s], data);
         chk("R5", "fill calc_en", 32'(calc_en[s]), 32'd0);
         chk("R5", "fill req_ready", 32'(req_ready[s]), 32'd1);
      end
   endtask

   task automatic t_reset();
      for (int s = 0; s < 2; s++) begin
         chk("R1", "req_ready", 32'(req_ready[s]), 32'd1);
         chk("R1", "calc_en", 32'(calc_en[s]), 32'd0);
         chk("R1", "rsp_valid", 32'(rsp_valid[s]), 32'd0);
         chk("R1", "hit_count", hit_count[s], 32'd0);
         chk("R1", "miss_count", miss_count[s], 32'd0);
      end
   endtask

   task automatic t_miss_then_hit();
      // R1: empty table, so the first lookup misses
      do_req(0, 16'h1234, 1'b0, res_of(16'h1234), "R1");
      do_req(0, 16'h1234, 1'b1, res_of(16'h1234), "R3");
      do_req(0, 16'h1234, 1'b1, res_of(16'h1234), "R3");
   endtask

   task automatic t_collision();
      // same set 0x34, different tag: a separate entry (R6)
      do_req(0, 16'h1274, 1'b0, res_of(16'h1274), "R6");
      do_req(0, 16'h1274, 1'b1, res_of(16'h1274), "R6");
      do_req(0, 16'h1234, 1'b1, res_of(16'h1234), "R6");
   endtask

   task automatic t_fill_evict();
      logic [15:0] k [6];
      for (int i = 1; i <= 5; i++) k[i] = 16'((i << 6) | 5);
      for (int i = 1; i <= 4; i++) do_req(0, k[i], 1'b0, res_of(k[i]), "R8");
      for (int i = 1; i <= 4; i++) do_req(0, k[i], 1'b1, res_of(k[i]), "R8");
      // tag 1 in set 6 does not match tag 1 in set 5 (R2)
      do_req(0, 16'h0046, 1'b0, res_of(16'h0046), "R2");
      // set 5 full: fifth tag replaces way 0 (k1)
      do_req(0, k[5], 1'b0, res_of(k[5]), "R9");
      do_req(0, k[2], 1'b1, res_of(k[2]), "R9");
      do_req(0, k[1], 1'b0, res_of(k[1]), "R9");  // evicts way 1 (k2)
      do_req(0, k[3], 1'b1, res_of(k[3]), "R9");
      do_req(0, k[2], 1'b0, res_of(k[2]), "R9");  // evicts way 2 (k3)
      do_req(0, k[4], 1'b1, res_of(k[4]), "R9");
      do_req(0, k[5], 1'b1, res_of(k[5]), "R9");
      do_req(0, k[3], 1'b0, res_of(k[3]), "R9");  // evicts way 3 (k4)
      do_req(0, k[1], 1'b1, res_of(k[1]), "R9");
   endtask

   task automatic t_short_tag();
      // set 3, tags 1, 2, 3, 4 ; with two tag bits dropped 1..3 share stored tag 0
      do_req(1, 16'h0043, 1'b0, res_of(16'h0043), "R7");
      do_req(1, 16'h0083, 1'b1, res_of(16'h0043), "R7");
      do_req(1, 16'h00C3, 1'b1, res_of(16'h0043), "R7");
      do_req(1, 16'h0103, 1'b0, res_of(16'h0103), "R7");
      // full-tag instance keeps them apart
      do_req(0, 16'h0043, 1'b0, res_of(16'h0043), "R7");
      do_req(0, 16'h0083, 1'b0, res_of(16'h0083), "R7");
      do_req(0, 16'h0043, 1'b1, res_of(16'h0043), "R7");
   endtask

   task automatic t_counters();
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
         chk("R10", "hit_count", hit_count[s], 32'(exp_hits[s]));
         chk("R10", "miss_count", miss_count[s], 32'(exp_misses[s]));
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < 2; s++) begin
         req_valid[s]   = 1'b0;
         req_key[s]     = '0;
         calc_done[s]   = 1'b0;
         calc_result[s] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_miss_then_hit();
      t_collision();
      t_fill_evict();
      t_short_tag();
      t_counters();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule